// File: doc/BRIEF.md
# Serial Transmitter with Break Control

This block turns bytes written over a simple bus-side port into asynchronous serial frames on a single TX pin. It has one holding register in front of a frame shifter. A `tx_empty` flag tells software when the held byte has moved into the shifter. Software acknowledges the flag by clearing it. The next byte it writes is then sent at the next free baud tick. The shifter moves one bit per `baud_tick` pulse. Baud generation is outside the block.

Each frame has one low start bit, the data bits least significant first, an optional parity bit (even or odd) and one or two high stop bits. The holding register accepts a write at any moment. A write that arrives before the previous byte has reached the shifter replaces that byte, and the replaced byte is never sent.

Dropping `tx_enable` stops the shifter at once. Control of the pin then passes to a software port path, which sets the pin's level and its output enable. A break is sent this way: software sets the port level low in push-pull mode, then disables transmission, and the pin stays low until transmission is enabled again.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset `tx_empty` is 1 and the shifter is idle. While `tx_enable` is 1, `tx_pin_oe` is 1 and an idle line drives `tx_pin` high.
- R2: A frame begins with one low start bit, followed by the `DATA_W` data bits least significant first. Each bit stays on `tx_pin` from one `baud_tick` to the next. Between ticks the pin does not change while transmission is enabled.
- R3: When `par_en` is 1, a parity bit follows the data. With `par_odd` at 0 it is the XOR of the data bits (even parity). With `par_odd` at 1 it is the inverse of that XOR (odd parity).
- R4: The frame ends with one high stop bit when `two_stop` is 0 and two when it is 1. The framing inputs are captured when the byte enters the shifter.
- R5: `tx_empty` rises to 1 in the same clock edge in which a `baud_tick` copies the held byte into the shifter.
- R6: A write on `wr_en` is accepted whatever the value of `tx_empty`. A second write before the transfer replaces the held byte, and only the last byte written is sent.
- R7: A pulse on `empty_clr` clears `tx_empty`, and that is the only way the flag falls. A transfer needs both the flag at 0 and a byte written since the previous transfer. A write while the flag is 1, or a clear with no new byte, starts nothing.
- R8: A byte that is ready when the last stop bit ends is loaded on that same tick. Its start bit follows the previous stop bit with no idle bit between them.
- R9: With `tx_enable` at 0 the frame in progress is abandoned and the shifter returns to idle. `tx_empty` reads 1 and `empty_clr` has no effect. Ticks while disabled send nothing, and a byte held when transmission was disabled is discarded.
- R10: While `tx_enable` is 0 the pin follows `pin_mode`:
  - 2'b00: pin released (`tx_pin_oe`=0, `tx_pin`=1).
  - 2'b01 and 2'b11: `pin_level` driven push-pull.
  - 2'b10: open drain, driving low only when `pin_level` is 0.
  
  While `tx_enable` is 1, `pin_mode` and `pin_level` have no effect on the pin.
- R11: A break is held while `tx_enable` is 0, `pin_mode` is 2'b01 and `pin_level` is 0: the pin is driven low across any number of ticks. After re-enabling, the pin returns to the idle high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| tx_enable | input | 1 | Transmit enable; 0 aborts and hands the pin to the port path |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to be sent |
| empty_clr | input | 1 | Clears the empty flag |
| pin_mode | input | 2 | Port-path pin mode used while disabled |
| pin_level | input | 1 | Port-path pin level used while disabled |
| tx_pin | output | 1 | Serial output level |
| tx_pin_oe | output | 1 | Output enable of the TX pin |
| tx_empty | output | 1 | Holding register has moved its byte into the shifter |

## Verification
The hardest situation to reach from the ports is a byte that becomes ready while a frame is still shifting. It has to be loaded on exactly the tick that ends the last stop bit. A close second is an abort in the middle of a frame, followed by a held break.

The bench generates `baud_tick` itself, one pulse at a time, so it always knows which bit the shifter is on. Directed sequences clear the flag and write the next byte mid-frame, then check for a start bit right after the final stop tick. Other sequences drop `tx_enable` a few bits into a frame and check the port-path pin over several ticks. Random frames with random data, parity and stop settings cover the framing.

// File: rtl/uart_brk_pkg.sv
// Shared types for the serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package uart_brk_pkg;

    // Framing options captured when a byte enters the shifter.
    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    // Port-path pin modes used while transmission is disabled.
    typedef enum logic [1:0] {
        PIN_RELEASE = 2'b00,
        PIN_PUSH    = 2'b01,
        PIN_OPEN    = 2'b10,
        PIN_PUSH_B  = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/tx_holdreg.sv
// Holding register and empty flag in front of the shifter.
// Accepts writes at any time; a transfer is requested only when a
// fresh byte is held and software has cleared the flag.
// Assumes: xfer_ack is asserted only while load_req is 1.
module tx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              empty_clr,
    input  logic              xfer_ack,
    output logic [DATA_W-1:0] hold_data,
    output logic              load_req,
    output logic              empty
);

    logic [DATA_W-1:0] data_q;
    logic              fresh_q;
    logic              empty_q;

    // Capture writes at any time; the flag and the fresh marker track transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            fresh_q <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            if (wr_en) begin
                data_q <= wr_data;
            end
            if (!tx_enable) begin
                fresh_q <= 1'b0;
                empty_q <= 1'b1;
            end else begin
                if (wr_en) begin
                    fresh_q <= 1'b1;
                end else if (xfer_ack) begin
                    fresh_q <= 1'b0;
                end
                if (xfer_ack) begin
                    empty_q <= 1'b1;
                end else if (empty_clr) begin
                    empty_q <= 1'b0;
                end
            end
        end
    end

    // Present the held byte and the transfer request.
    always_comb begin
        hold_data = data_q;
        load_req  = fresh_q & ~empty_q;
        empty     = empty_q;
    end

endmodule

// File: rtl/tx_framer.sv
// Frame shifter: builds start/data/parity/stop frames and moves one bit
// per baud tick. A new frame is loaded on a tick while idle, or on
// the tick that ends the last stop bit.
// Assumes: baud_tick is a single-cycle pulse.
module tx_framer
    import uart_brk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_enable,
    input  frame_cfg_t        cfg,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ack,
    output logic              line
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   left_q;
    logic [FRAME_W-1:0] new_frame;
    logic [CNT_W-1:0]   new_len;
    logic               ready;

    // Assemble the frame image and its length from the held byte.
    always_comb begin
        new_frame              = '1;
        new_frame[0]           = 1'b0;
        new_frame[DATA_W:1]    = load_data;
        if (cfg.par_en) begin
            new_frame[DATA_W+1] = cfg.par_odd ? ~(^load_data) : (^load_data);
        end
        new_len = CNT_W'(DATA_W + 2) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
    end

    // Decide whether this tick loads a new frame.
    always_comb begin
        ready    = (left_q <= CNT_W'(1));
        load_ack = baud_tick & tx_enable & load_req & ready;
    end

    // Shift one bit per tick, reload or go idle at frame end, abort when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '1;
            left_q  <= '0;
        end else if (!tx_enable) begin
            frame_q <= '1;
            left_q  <= '0;
        end else if (load_ack) begin
            frame_q <= new_frame;
            left_q  <= new_len;
        end else if (baud_tick && left_q != '0) begin
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            left_q  <= left_q - CNT_W'(1);
        end
    end

    // Idle line is high; otherwise the current frame bit.
    always_comb begin
        line = (left_q != '0) ? frame_q[0] : 1'b1;
    end

endmodule

// File: rtl/tx_pinmux.sv
// Selects who controls the TX pin: the shifter while enabled, the
// software port path (mode and level) while disabled.
// Assumes: purely combinational; no pin synchronisation needed.
module tx_pinmux
    import uart_brk_pkg::*;
(
    input  logic       tx_enable,
    input  logic       line,
    input  logic [1:0] pin_mode,
    input  logic       pin_level,
    output logic       tx_pin,
    output logic       tx_pin_oe
);

    // Route the shifter or the port path to the pin.
    always_comb begin
        tx_pin    = 1'b1;
        tx_pin_oe = 1'b0;
        if (tx_enable) begin
            tx_pin    = line;
            tx_pin_oe = 1'b1;
        end else begin
            case (pin_mode_e'(pin_mode))
                PIN_PUSH, PIN_PUSH_B: begin
                    tx_pin    = pin_level;
                    tx_pin_oe = 1'b1;
                end
                PIN_OPEN: begin
                    tx_pin    = pin_level;
                    tx_pin_oe = ~pin_level;
                end
                default: begin
                    tx_pin    = 1'b1;
                    tx_pin_oe = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_brk_tx.sv
// Serial transmitter top: holding register, frame shifter and pin
// selector with a software port path used for breaks.
// Assumes: baud_tick comes from an external divider; all inputs are
// synchronous to clk.
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_enable,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              empty_clr,
    input  logic [1:0]        pin_mode,
    input  logic              pin_level,
    output logic              tx_pin,
    output logic              tx_pin_oe,
    output logic              tx_empty
);

    logic [DATA_W-1:0] hold_data;
    logic              load_req;
    logic              load_ack;
    logic              line;
    frame_cfg_t        cfg;

    // Gather the framing options into one word.
    always_comb begin
        cfg.par_en   = par_en;
        cfg.par_odd  = par_odd;
        cfg.two_stop = two_stop;
    end

    tx_holdreg #(.DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_enable (tx_enable),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .empty_clr (empty_clr),
        .xfer_ack  (load_ack),
        .hold_data (hold_data),
        .load_req  (load_req),
        .empty     (tx_empty)
    );

    tx_framer #(.DATA_W(DATA_W)) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_enable (tx_enable),
        .cfg       (cfg),
        .load_req  (load_req),
        .load_data (hold_data),
        .load_ack  (load_ack),
        .line      (line)
    );

    tx_pinmux mux_i (
        .tx_enable (tx_enable),
        .line      (line),
        .pin_mode  (pin_mode),
        .pin_level (pin_level),
        .tx_pin    (tx_pin),
        .tx_pin_oe (tx_pin_oe)
    );

endmodule

// File: rtl/uart_brk_tx_chk.sv
// Property checker for the serial transmitter, bound to its top.
// Assumes: observes top-level ports only.
module uart_brk_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              tx_enable,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              empty_clr,
    input logic [1:0]        pin_mode,
    input logic              pin_level,
    input logic              tx_pin,
    input logic              tx_pin_oe,
    input logic              tx_empty
);

    // R1
    enabled_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_enable |-> tx_pin_oe);

    // R2
    pin_steady_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && $past(tx_enable) && !$past(baud_tick)) |-> $stable(tx_pin));

    // R5
    empty_rises_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_empty) && $past(tx_enable)) |-> $past(baud_tick));

    // R7
    empty_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(empty_clr));

    // R9
    disabled_reads_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> tx_empty);

    // R10
    released_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && pin_mode == 2'b00) |-> !tx_pin_oe);

    // R11
    break_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && pin_mode == 2'b01 && !pin_level) |-> (!tx_pin && tx_pin_oe));

endmodule

bind uart_brk_tx uart_brk_tx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_enable (tx_enable),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .empty_clr (empty_clr),
    .pin_mode  (pin_mode),
    .pin_level (pin_level),
    .tx_pin    (tx_pin),
    .tx_pin_oe (tx_pin_oe),
    .tx_empty  (tx_empty)
);

// File: tb/uart_brk_tx_tb_top.sv
`timescale 1ns/1ps
module uart_brk_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_enable = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       empty_clr = 1'b0;
    logic [1:0] pin_mode = 2'b00;
    logic       pin_level = 1'b1;
    logic       tx_pin;
    logic       tx_pin_oe;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_brk_tx #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .wr_en(wr_en), .wr_data(wr_data), .empty_clr(empty_clr),
        .pin_mode(pin_mode), .pin_level(pin_level),
        .tx_pin(tx_pin), .tx_pin_oe(tx_pin_oe), .tx_empty(tx_empty)
    );

    function automatic logic [11:0] exp_bits(input logic [7:0] d, input logic pe, input logic po);
        logic [11:0] e;
        e = '1;
        e[0] = 1'b0;
        for (int i = 0; i < 8; i++) e[i+1] = d[i];
        if (pe) e[9] = po ? ~(^d) : (^d);
        return e;
    endfunction

    function automatic int exp_len(input logic pe, input logic ts);
        return 10 + int'(pe) + int'(ts);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk) empty_clr = 1'b1;
        @(negedge clk) empty_clr = 1'b0;
    endtask

    // Shift out the rest of a frame whose start bit is on the pin, then check idle.
    task automatic rest_of_frame(input logic [7:0] d, input logic pe, input logic po,
                                 input logic ts, input bit check_idle);
        logic [11:0] e;
        int n;
        e = exp_bits(d, pe, po);
        n = exp_len(pe, ts);
        for (int i = 1; i < n; i++) begin
            tick();
            if (i <= 8)                chk("R2 data bit", tx_pin, e[i]);
            else if (pe && i == 9)     chk("R3 parity bit", tx_pin, e[i]);
            else                       chk("R4 stop bit", tx_pin, 1'b1);
        end
        if (check_idle) begin
            tick();
            chk("R2 idle after frame", tx_pin, 1'b1);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pe, input logic po, input logic ts);
        par_en = pe; par_odd = po; two_stop = ts;
        clr();
        wr(d);
        chk("R7 flag cleared", tx_empty, 1'b0);
        tick();
        chk("R5 flag set on transfer", tx_empty, 1'b1);
        chk("R2 start bit", tx_pin, 1'b0);
        rest_of_frame(d, pe, po, ts, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty after reset", tx_empty, 1'b1);
        chk("R1 idle pin high", tx_pin, 1'b1);
        chk("R1 pin driven", tx_pin_oe, 1'b1);

        // R2 R3 R4 directed framings
        send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
        send_frame(8'h01, 1'b1, 1'b0, 1'b0);
        send_frame(8'h01, 1'b1, 1'b1, 1'b1);
        send_frame(8'h00, 1'b1, 1'b1, 1'b0);

        // R6 overwrite: only the last write is sent
        par_en = 1'b0; two_stop = 1'b0;
        clr();
        wr(8'h3C);
        wr(8'hC3);
        tick();
        chk("R6 start after overwrite", tx_pin, 1'b0);
        rest_of_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);

        // R7 write while flag is 1 starts nothing; clear then starts it
        wr(8'h5A);
        tick();
        chk("R7 no start while flag set", tx_pin, 1'b1);
        chk("R7 flag still set", tx_empty, 1'b1);
        clr();
        tick();
        chk("R7 start after clear", tx_pin, 1'b0);
        rest_of_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
        // R7 clear with no fresh byte starts nothing
        clr();
        tick();
        chk("R7 clear alone no start", tx_pin, 1'b1);
        wr(8'h81);
        tick();
        chk("R7 write after clear starts", tx_pin, 1'b0);
        rest_of_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);

        // R8 back-to-back frames with no idle bit
        clr();
        wr(8'h96);
        tick();
        chk("R8 first start", tx_pin, 1'b0);
        clr();
        wr(8'h69);
        rest_of_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R8 second start right after stop", tx_pin, 1'b0);
        chk("R8 flag set on second transfer", tx_empty, 1'b1);
        rest_of_frame(8'h69, 1'b0, 1'b0, 1'b0, 1'b1);

        // R9 abort mid-frame
        clr();
        wr(8'h00);
        tick(); tick(); tick();
        @(negedge clk) begin tx_enable = 1'b0; pin_mode = 2'b00; end
        @(negedge clk);
        chk("R9 empty while disabled", tx_empty, 1'b1);
        chk("R10 released pin oe", tx_pin_oe, 1'b0);
        clr();
        chk("R9 clear ignored when disabled", tx_empty, 1'b1);
        tick();
        @(negedge clk) tx_enable = 1'b1;
        @(negedge clk);
        chk("R9 idle after re-enable", tx_pin, 1'b1);
        tick();
        chk("R9 nothing resumes", tx_pin, 1'b1);
        chk("R9 flag stays set", tx_empty, 1'b1);

        // R10 port-path modes while disabled
        @(negedge clk) begin tx_enable = 1'b0; pin_mode = 2'b01; pin_level = 1'b1; end
        @(negedge clk);
        chk("R10 push high", {tx_pin_oe, tx_pin}, 2'b11);
        @(negedge clk) pin_level = 1'b0;
        @(negedge clk);
        chk("R10 push low", {tx_pin_oe, tx_pin}, 2'b10);
        @(negedge clk) pin_mode = 2'b10;
        @(negedge clk);
        chk("R10 open drain low", {tx_pin_oe, tx_pin}, 2'b10);
        @(negedge clk) pin_level = 1'b1;
        @(negedge clk);
        chk("R10 open drain released", tx_pin_oe, 1'b0);
        @(negedge clk) begin pin_mode = 2'b11; pin_level = 1'b0; end
        @(negedge clk);
        chk("R10 alt push low", {tx_pin_oe, tx_pin}, 2'b10);
        @(negedge clk) pin_mode = 2'b00;
        @(negedge clk);
        chk("R10 release", {tx_pin_oe, tx_pin}, 2'b01);

        // R11 break: port level low, then disable mid-frame
        @(negedge clk) begin tx_enable = 1'b1; pin_mode = 2'b01; pin_level = 1'b0; end
        clr();
        wr(8'hFF);
        tick();
        tick();
        chk("R10 port path ignored while enabled", tx_pin, 1'b1);
        tick();
        @(negedge clk) tx_enable = 1'b0;
        @(negedge clk);
        chk("R11 break low", {tx_pin_oe, tx_pin}, 2'b10);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R11 break held across ticks", {tx_pin_oe, tx_pin}, 2'b10);
        end
        @(negedge clk) begin tx_enable = 1'b1; pin_level = 1'b1; end
        @(negedge clk);
        chk("R11 idle high after break", tx_pin, 1'b1);
        tick();
        chk("R11 still idle", tx_pin, 1'b1);

        // R2 R3 R4 random frames
        for (int k = 0; k < 40; k++) begin
            send_frame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule